// File: doc/BRIEF.md
# Split-Store Load Value Monitor

This block watches a single, already serialized stream of memory events coming from several processors and checks that every load returned a legal value. A store appears twice in the stream. Its local event is when the storing processor can first see the value. Its global event is when every processor can see it. Loads are checked against these two views. The monitor keeps a shadow copy of globally visible memory. For each processor it also keeps a table of stores that have been seen locally but have not yet gone global.

For each load, the expected value depends on who is loading. If the loading processor has its own outstanding local store to that address, the newest such value is expected. Otherwise the expected value is whatever the last global store wrote, and memory starts at zero. The expected value and the pass/fail result are reported one cycle after the load. The first violation raises a sticky error flag and captures the offending processor and address. A global event that no pending local store of the same processor accounts for also counts as a violation.

The block is placed next to a protocol model or design under test. It is fed one event per cycle.

Top module: `vo_read_checker`

## Requirements
- R1: After reset, `err_flag` and `chk_valid` are low and every address reads as zero for every processor.
- R2: An event is taken only in a cycle with `ev_valid` high. The `ev_kind` code 2'b00 is a local store, 2'b01 is a global store and 2'b10 is a load.
- R3: A load by a processor that holds an outstanding local store to the same address expects the data of that processor's newest local store to that address.
- R4: A load by a processor with no outstanding local store to the address expects the data of the most recent global store to that address. This holds even when another processor has a local store outstanding there.
- R5: A global store always updates the shadow memory. It retires the processor's outstanding entry for that address only when its data equals the newest local data. Otherwise the entry stays outstanding.
- R6: The cycle after a load event, `chk_valid` is high for exactly one cycle. `chk_exp` then holds the expected value, and `chk_bad` is high exactly when the loaded data differed from it.
- R7: A load mismatch sets `err_flag`, which stays high until reset.
- R8: `err_cpu` and `err_addr` capture the processor and address of the first faulting event. Later faults leave them unchanged.
- R9: A global store from a processor with no outstanding local store to that address is a fault, and it still updates the shadow memory.
- R10: The code 2'b11, and any event with `ev_valid` low, changes no state and raises no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | Event code: 00 local store, 01 global store, 10 load, 11 none |
| ev_cpu | input | CW (1) | Issuing processor |
| ev_addr | input | AW (3) | Memory location |
| ev_data | input | DW (8) | Stored data or loaded data |
| chk_valid | output | 1 | A load result is reported this cycle |
| chk_exp | output | DW (8) | Value the load should have returned |
| chk_bad | output | 1 | Reported load mismatched |
| err_flag | output | 1 | Sticky violation flag |
| err_cpu | output | CW (1) | Processor of the first violation |
| err_addr | output | AW (3) | Address of the first violation |

## Verification
The embedded properties assume the following about the input stream:
- There is at most one event per cycle.
- `ev_cpu` is always below the processor count.
- Inputs are stable across the sampling edge.

The bench drives inputs only at falling edges and uses just the two default processors. It builds most global stores from entries its own model still holds as outstanding. It also deliberately injects orphan globals, wrong load data, reserved codes and invalid cycles, so that the fault paths and the ignore paths are both exercised.

// File: rtl/vo_pkg.sv
package vo_pkg;

    localparam int DEF_NCPU  = 2;
    localparam int DEF_NADDR = 8;
    localparam int DEF_DW    = 8;

    typedef enum logic [1:0] {
        EV_LST  = 2'b00,
        EV_GST  = 2'b01,
        EV_LOAD = 2'b10,
        EV_NONE = 2'b11
    } ev_kind_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vo_shadow_mem.sv
module vo_shadow_mem #(
    parameter int NADDR = vo_pkg::DEF_NADDR,
    parameter int DW    = vo_pkg::DEF_DW,
    localparam int AW   = vo_pkg::idx_width(NADDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [NADDR*DW-1:0] words;

    for (genvar g = 0; g < NADDR; g++) begin : g_word
        logic [DW-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && wr_addr == AW'(g)) begin
                word_q <= wr_data;
            end
        end

        assign words[g*DW +: DW] = word_q;

        // R5
        global_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == AW'(g)) |=> (word_q == $past(wr_data)));
    end

    assign rd_data = words[rd_addr*DW +: DW];

endmodule

// File: rtl/vo_pending_table.sv
module vo_pending_table #(
    parameter int NADDR = vo_pkg::DEF_NADDR,
    parameter int DW    = vo_pkg::DEF_DW,
    localparam int AW   = vo_pkg::idx_width(NADDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic          glob_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          hit_valid,
    output logic [DW-1:0] hit_data
);

    logic [NADDR-1:0]    valid_vec;
    logic [NADDR*DW-1:0] data_vec;

    for (genvar g = 0; g < NADDR; g++) begin : g_entry
        logic          v_q;
        logic [DW-1:0] d_q;
        logic          sel;

        assign sel = (addr == AW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (set_en && sel) begin
                v_q <= 1'b1;
                d_q <= data;
            end else if (glob_en && sel && v_q && d_q == data) begin
                v_q <= 1'b0;
            end
        end

        assign valid_vec[g]          = v_q;
        assign data_vec[g*DW +: DW]  = d_q;

        // R3
        local_store_pends_chk: assert property (@(posedge clk) disable iff (rst)
            (set_en && sel) |=> (v_q && d_q == $past(data)));

        // R5
        older_global_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (glob_en && sel && v_q && d_q != data) |=> (v_q && $stable(d_q)));
    end

    assign hit_valid = valid_vec[addr];
    assign hit_data  = data_vec[addr*DW +: DW];

endmodule

// File: rtl/vo_read_checker.sv
module vo_read_checker #(
    parameter int NCPU  = vo_pkg::DEF_NCPU,
    parameter int NADDR = vo_pkg::DEF_NADDR,
    parameter int DW    = vo_pkg::DEF_DW,
    localparam int CW   = vo_pkg::idx_width(NCPU),
    localparam int AW   = vo_pkg::idx_width(NADDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    input  logic [1:0]    ev_kind,
    input  logic [CW-1:0] ev_cpu,
    input  logic [AW-1:0] ev_addr,
    input  logic [DW-1:0] ev_data,
    output logic          chk_valid,
    output logic [DW-1:0] chk_exp,
    output logic          chk_bad,
    output logic          err_flag,
    output logic [CW-1:0] err_cpu,
    output logic [AW-1:0] err_addr
);
    import vo_pkg::*;

    ev_kind_e kind;
    logic     is_lst, is_gst, is_load;

    assign kind    = ev_kind_e'(ev_kind);
    assign is_lst  = ev_valid && (kind == EV_LST);
    assign is_gst  = ev_valid && (kind == EV_GST);
    assign is_load = ev_valid && (kind == EV_LOAD);

    logic [NCPU-1:0] pend_hit;
    logic [DW-1:0]   pend_data [NCPU];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic mine;
        assign mine = (ev_cpu == CW'(c));

        vo_pending_table #(.NADDR(NADDR), .DW(DW)) u_pend (
            .clk      (clk),
            .rst      (rst),
            .set_en   (is_lst && mine),
            .glob_en  (is_gst && mine),
            .addr     (ev_addr),
            .data     (ev_data),
            .hit_valid(pend_hit[c]),
            .hit_data (pend_data[c])
        );
    end

    logic [DW-1:0] shadow_rd;

    vo_shadow_mem #(.NADDR(NADDR), .DW(DW)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (is_gst),
        .wr_addr(ev_addr),
        .wr_data(ev_data),
        .rd_addr(ev_addr),
        .rd_data(shadow_rd)
    );

    logic          own_hit;
    logic [DW-1:0] expect_val;
    logic          load_bad, orphan, fault;

    always_comb begin
        own_hit    = pend_hit[ev_cpu];
        expect_val = own_hit ? pend_data[ev_cpu] : shadow_rd;
        load_bad   = is_load && (ev_data != expect_val);
        orphan     = is_gst && !own_hit;
        fault      = load_bad || orphan;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_valid <= 1'b0;
            chk_exp   <= '0;
            chk_bad   <= 1'b0;
            err_flag  <= 1'b0;
            err_cpu   <= '0;
            err_addr  <= '0;
        end else begin
            chk_valid <= is_load;
            chk_bad   <= load_bad;
            if (is_load) begin
                chk_exp <= expect_val;
            end
            if (fault && !err_flag) begin
                err_cpu  <= ev_cpu;
                err_addr <= ev_addr;
            end
            err_flag <= err_flag || fault;
        end
    end

    // R6
    report_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> $past(ev_valid && ev_kind == 2'b10));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R7
    bad_raises_flag_chk: assert property (@(posedge clk) disable iff (rst)
        chk_bad |-> (chk_valid && err_flag));

    // R8
    first_fault_held_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> ($stable(err_cpu) && $stable(err_addr)));

    // R10
    idle_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_flag && !(ev_valid && ev_kind != 2'b11)) |=> !err_flag);

endmodule

// File: tb/vo_read_checker_tb.sv
`timescale 1ns/1ps
module vo_read_checker_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0;
    logic [1:0] ev_kind = 2'b11;
    logic [0:0] ev_cpu = '0;
    logic [2:0] ev_addr = '0;
    logic [7:0] ev_data = '0;
    logic       chk_valid, chk_bad, err_flag;
    logic [7:0] chk_exp;
    logic [0:0] err_cpu;
    logic [2:0] err_addr;

    always #4 clk = ~clk;

    vo_read_checker u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_cpu(ev_cpu), .ev_addr(ev_addr), .ev_data(ev_data),
        .chk_valid(chk_valid), .chk_exp(chk_exp), .chk_bad(chk_bad),
        .err_flag(err_flag), .err_cpu(err_cpu), .err_addr(err_addr)
    );

    // behavioural reference
    bit [7:0] m_mem [8];
    bit       m_pv  [2][8];
    bit [7:0] m_pd  [2][8];
    bit       m_chk_valid, m_chk_bad, m_err;
    bit [7:0] m_chk_exp;
    int       m_ecpu, m_eaddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic model_reset();
        for (int a = 0; a < 8; a++) begin
            m_mem[a] = 0;
            for (int c = 0; c < 2; c++) begin m_pv[c][a] = 0; m_pd[c][a] = 0; end
        end
        m_chk_valid = 0; m_chk_bad = 0; m_chk_exp = 0;
        m_err = 0; m_ecpu = 0; m_eaddr = 0;
    endtask

    function automatic bit [7:0] model_expect(int cpu, int addr);
        return m_pv[cpu][addr] ? m_pd[cpu][addr] : m_mem[addr];
    endfunction

    task automatic model_fault(int cpu, int addr);
        if (!m_err) begin m_ecpu = cpu; m_eaddr = addr; end
        m_err = 1;
    endtask

    task automatic model_step(bit v, bit [1:0] kd, int cpu, int addr, bit [7:0] d);
        m_chk_valid = 0;
        m_chk_bad   = 0;
        if (!v) return;
        case (kd)
            2'b00: begin m_pv[cpu][addr] = 1; m_pd[cpu][addr] = d; end
            2'b01: begin
                if (!m_pv[cpu][addr]) model_fault(cpu, addr);
                else if (m_pd[cpu][addr] == d) m_pv[cpu][addr] = 0;
                m_mem[addr] = d;
            end
            2'b10: begin
                m_chk_valid = 1;
                m_chk_exp   = model_expect(cpu, addr);
                m_chk_bad   = (m_chk_exp != d);
                if (m_chk_bad) model_fault(cpu, addr);
            end
            default: ;
        endcase
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(string req);
        check(chk_valid == m_chk_valid, req, "chk_valid", chk_valid, m_chk_valid);
        if (m_chk_valid) begin
            check(chk_exp == m_chk_exp, req, "chk_exp", chk_exp, m_chk_exp);
            check(chk_bad == m_chk_bad, req, "chk_bad", chk_bad, m_chk_bad);
        end
        check(err_flag == m_err, req, "err_flag", err_flag, m_err);
        if (m_err) begin
            check(err_cpu == m_ecpu, req, "err_cpu", err_cpu, m_ecpu);
            check(err_addr == m_eaddr, req, "err_addr", err_addr, m_eaddr);
        end
    endtask

    task automatic do_ev(bit v, bit [1:0] kd, int cpu, int addr, bit [7:0] d, string req);
        @(negedge clk);
        ev_valid = v; ev_kind = kd; ev_cpu = 1'(cpu); ev_addr = 3'(addr); ev_data = d;
        model_step(v, kd, cpu, addr, d);
        @(negedge clk);
        compare(req);
        ev_valid = 0;
        m_chk_valid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; ev_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
        compare("R1");
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: fresh memory reads zero for both processors
        do_ev(1, 2'b10, 0, 0, 8'd0, "R1");
        do_ev(1, 2'b10, 1, 7, 8'd0, "R1");

        // R2 R3 R4: processor 1 stores locally
        do_ev(1, 2'b00, 1, 3, 8'd1, "R2");
        do_ev(1, 2'b10, 1, 3, 8'd1, "R3");
        do_ev(1, 2'b10, 0, 3, 8'd0, "R4");
        do_ev(1, 2'b01, 1, 3, 8'd1, "R5");
        do_ev(1, 2'b10, 0, 3, 8'd1, "R4");
        do_ev(1, 2'b10, 1, 3, 8'd1, "R5");

        // R5: two outstanding locals, older goes global first
        do_ev(1, 2'b00, 0, 5, 8'd7, "R2");
        do_ev(1, 2'b00, 0, 5, 8'd9, "R3");
        do_ev(1, 2'b10, 0, 5, 8'd9, "R3");
        do_ev(1, 2'b01, 0, 5, 8'd7, "R5");
        do_ev(1, 2'b10, 0, 5, 8'd9, "R5");
        do_ev(1, 2'b10, 1, 5, 8'd7, "R4");
        do_ev(1, 2'b01, 0, 5, 8'd9, "R5");
        do_ev(1, 2'b10, 0, 5, 8'd9, "R5");
        do_ev(1, 2'b10, 1, 5, 8'd9, "R5");

        // R10: reserved code and invalid cycles touch nothing
        do_ev(1, 2'b11, 0, 2, 8'd5, "R10");
        do_ev(0, 2'b00, 0, 2, 8'd6, "R10");
        do_ev(0, 2'b01, 1, 2, 8'd6, "R10");
        do_ev(0, 2'b10, 0, 2, 8'd99, "R10");
        do_ev(1, 2'b10, 0, 2, 8'd0, "R10");
        do_ev(1, 2'b10, 1, 2, 8'd0, "R10");

        // R6 R7 R8: wrong load data
        do_ev(1, 2'b10, 1, 5, 8'd3, "R7");
        do_ev(1, 2'b10, 0, 4, 8'd0, "R6");
        // R9 R8: orphan global after first fault, shadow still written
        do_ev(1, 2'b01, 0, 6, 8'd42, "R9");
        do_ev(1, 2'b10, 1, 6, 8'd42, "R9");
        do_ev(1, 2'b10, 0, 6, 8'd1, "R8");

        // R1 R7: reset clears the sticky flag
        do_reset();
        do_ev(1, 2'b10, 1, 6, 8'd0, "R1");
        // R9: orphan global on a clean run
        do_ev(1, 2'b01, 0, 1, 8'd8, "R9");
        do_ev(1, 2'b10, 1, 1, 8'd8, "R9");

        // randomized stream checked against the model
        for (int blk = 0; blk < 4; blk++) begin
            do_reset();
            for (int i = 0; i < 150; i++) begin
                int cpu = int'($urandom_range(0, 1));
                int addr = int'($urandom_range(0, 7));
                int sel = int'($urandom_range(0, 9));
                bit [7:0] d = 8'($urandom_range(0, 255));
                if (sel < 3) begin
                    do_ev(1, 2'b00, cpu, addr, d, "R3");
                end else if (sel < 5) begin
                    if (m_pv[cpu][addr]) d = m_pd[cpu][addr];
                    else if (sel == 4 && $urandom_range(0, 3) == 0) d = d;
                    else begin
                        d = 8'($urandom_range(0, 255));
                        do_ev(1, 2'b00, cpu, addr, d, "R5");
                    end
                    do_ev(1, 2'b01, cpu, addr, d, "R5");
                end else if (sel < 9) begin
                    bit [7:0] e = model_expect(cpu, addr);
                    if ($urandom_range(0, 15) == 0) e = e ^ 8'h10;
                    do_ev(1, 2'b10, cpu, addr, e, "R4");
                end else begin
                    do_ev(1, 2'b11, cpu, addr, d, "R10");
                end
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule